// File: doc/BRIEF.md
# Serial Debug Probe Streamer

The block holds four debug probe values and sends them out on one serial pin each time a periodic computation engine begins a pass. The engine signals a pass start with a one-cycle strobe. If streaming is enabled and no burst is running, the block takes a snapshot of all four probes and emits a frame. The frame is one high start bit followed by forty data bits, and a companion strobe marks every data bit so that a logic analyser or a capture block can sample the pin.

Probe 0 carries ten significant bits. Probes 1, 2 and 3 keep eight bits each and are sent as ten-bit words whose two top bits are zero. Software loads the probes and the enable flag through a simple write port. While the enable flag is clear, the pin stays low and the probes have no effect on it.

Top module: `probe_streamer`

## Requirements
- R1: After a synchronous reset, `busy`, `ser_out` and `ser_strobe` are low, the enable flag is 0 and all four probes read as zero in the next burst.
- R2: A write with `wr_en` high stores `wr_data` into probe N when `wr_addr` is N (0 to 3), and stores `wr_data[0]` into the enable flag when `wr_addr` is 4. Writes to addresses 5 to 7 change nothing.
- R3: If `pass_start` is high at a clock edge while enabled and idle, then from that edge on `busy` is high and `ser_out` carries the start bit (high) with `ser_strobe` low for one cycle.
- R4: After the start bit, forty data bits follow, one per cycle, with `ser_strobe` high for each. The words go out in probe order 0, 1, 2, 3, and each ten-bit word is sent MSB first.
- R5: Probes 1 to 3 store only `wr_data[7:0]`. They are transmitted with the two upper bits of their ten-bit word as 00. Probe 0 stores and sends all ten bits.
- R6: `busy` stays high for exactly 41 cycles (start bit plus 40 data bits) and then drops, with `ser_out` and `ser_strobe` low.
- R7: The frame carries the probe values held at the pass-start edge. Probe writes made during a burst do not alter it and appear in the next burst.
- R8: A `pass_start` pulse while `busy` is high is ignored. The current frame continues unchanged, and no second frame follows it.
- R9: While the enable flag is 0, `ser_out`, `ser_strobe` and `busy` stay low and `pass_start` has no effect.
- R10: Clearing the enable flag during a burst aborts it. From the write edge on, `ser_out`, `ser_strobe` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 probes, 4 enable flag |
| wr_data | input | 10 | Write data |
| pass_start | input | 1 | One-cycle pulse at the start of an engine pass |
| busy | output | 1 | High while a frame is being sent |
| ser_out | output | 1 | Serial probe data pin |
| ser_strobe | output | 1 | High for one cycle on every data bit |

## Verification
The start bit is visible in the cycle right after the edge that samples `pass_start`. Data bit k is visible k+1 cycles after that edge, and `busy` falls 41 cycles after it. Register writes and an abort take effect in the cycle right after their own edge. The bench drives every input at a falling edge and samples the outputs at the following falling edge, so each sample shows the state after exactly one rising edge. Each expected value is tied to a cycle count from the edge that caused it.

// File: rtl/probe_stream_pkg.sv
package probe_stream_pkg;

    parameter int unsigned PS_NUM_PROBES = 4;
    parameter int unsigned PS_WORD_W     = 10;
    parameter int unsigned PS_NARROW_W   = 8;
    parameter int unsigned PS_ADDR_W     = 3;

    localparam int unsigned PS_FRAME_W = PS_NUM_PROBES * PS_WORD_W;
    localparam int unsigned PS_CNT_W   = $clog2(PS_FRAME_W);
    localparam logic [PS_ADDR_W-1:0] PS_ENABLE_ADDR = PS_ADDR_W'(PS_NUM_PROBES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } ps_state_e;

    typedef struct packed {
        logic                 we;
        logic [PS_ADDR_W-1:0] addr;
        logic [PS_WORD_W-1:0] data;
    } ps_wr_t;

    // Probe 0 keeps the full word; the others keep only the narrow field.
    function automatic logic [PS_WORD_W-1:0] ps_fit(input logic [PS_WORD_W-1:0] v,
                                                    input int unsigned idx);
        logic [PS_WORD_W-1:0] mask;
        mask = '0;
        mask[PS_NARROW_W-1:0] = '1;
        return (idx == 0) ? v : (v & mask);
    endfunction

endpackage

// File: rtl/probe_bank.sv
module probe_bank
    import probe_stream_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  ps_wr_t                wr,
    output logic [PS_FRAME_W-1:0] frame_o,
    output logic                  en_o
);

    for (genvar g = 0; g < PS_NUM_PROBES; g++) begin : g_probe
        logic [PS_WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr.we && wr.addr == PS_ADDR_W'(g)) begin
                word_q <= ps_fit(wr.data, g);
            end
        end

        // Probe 0 occupies the most significant word so it is sent first.
        assign frame_o[PS_FRAME_W-1-g*PS_WORD_W -: PS_WORD_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= 1'b0;
        end else if (wr.we && wr.addr == PS_ENABLE_ADDR) begin
            en_o <= wr.data[0];
        end
    end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import probe_stream_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  start_i,
    input  logic [PS_FRAME_W-1:0] frame_i,
    output logic                  ser_o,
    output logic                  stb_o,
    output logic                  busy_o
);

    localparam logic [PS_CNT_W-1:0] LAST = PS_CNT_W'(PS_FRAME_W - 1);

    ps_state_e             state_q;
    logic [PS_CNT_W-1:0]   cnt_q;
    logic [PS_FRAME_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_START;
                        shreg_q <= frame_i;
                        cnt_q   <= '0;
                    end
                end
                ST_START: state_q <= ST_DATA;
                ST_DATA: begin
                    shreg_q <= shreg_q << 1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o = en_i && (state_q != ST_IDLE);
        stb_o  = en_i && (state_q == ST_DATA);
        ser_o  = en_i && ((state_q == ST_START) ||
                          (state_q == ST_DATA && shreg_q[PS_FRAME_W-1]));
    end

    assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (ser_o && !stb_o));

    assert_strobe_inside_R4: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> busy_o);

    assert_burst_len_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && en_i) |-> ($past(cnt_q) == LAST));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && cnt_q != LAST && en_i)
            |=> (state_q == ST_DATA && cnt_q == $past(cnt_q) + 1'b1));

    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !busy_o);

endmodule

// File: rtl/probe_streamer.sv
module probe_streamer
    import probe_stream_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PS_ADDR_W-1:0] wr_addr,
    input  logic [PS_WORD_W-1:0] wr_data,
    input  logic                 pass_start,
    output logic                 busy,
    output logic                 ser_out,
    output logic                 ser_strobe
);

    ps_wr_t                wr;
    logic [PS_FRAME_W-1:0] frame;
    logic                  en;

    assign wr = '{we: wr_en, addr: wr_addr, data: wr_data};

    probe_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .frame_o (frame),
        .en_o    (en)
    );

    frame_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .start_i (pass_start),
        .frame_i (frame),
        .ser_o   (ser_out),
        .stb_o   (ser_strobe),
        .busy_o  (busy)
    );

    // Disabling takes effect on the pin right after the write edge.
    assert_abort_low_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == PS_ENABLE_ADDR && !wr_data[0]) |=> (!ser_out && !busy));

endmodule

// File: tb/test_probe_streamer.sv
module test_probe_streamer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       pass_start = 1'b0;
    logic       busy, ser_out, ser_strobe;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    probe_streamer i_probe_streamer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pass_start (pass_start),
        .busy       (busy),
        .ser_out    (ser_out),
        .ser_strobe (ser_strobe)
    );

    // Each row: raw write data for probes 0..3, ten bits each.
    localparam logic [39:0] VEC [5] = '{
        {10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF},
        {10'h200, 10'h001, 10'h080, 10'h155},
        {10'h155, 10'h2AA, 10'h0FF, 10'h300},
        {10'h001, 10'h100, 10'h200, 10'h3FE},
        {10'h0C3, 10'h05A, 10'h1A5, 10'h2F0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] expect_frame(input logic [39:0] raw);
        return {raw[39:30], 2'b00, raw[27:20], 2'b00, raw[17:10], 2'b00, raw[7:0]};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [9:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [39:0] raw);
        for (int i = 0; i < 4; i++) wr_reg(3'(i), raw[39-10*i -: 10]);
    endtask

    // act: 0 none, 1 write probe 0 mid-burst, 2 pass_start mid-burst, 3 abort
    task automatic burst(input logic [39:0] exp, input string tag,
                         input int act, input int act_at);
        logic [39:0] got;
        int strobes, busys, quiet_bad;
        got = '0; strobes = 0; busys = 0; quiet_bad = 0;
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        chk(ser_out && !ser_strobe && busy, {"R3 start bit ", tag},
            {ser_out, ser_strobe, busy}, 3'b101);
        busys++;
        for (int k = 0; k < 40; k++) begin
            if (k == act_at) begin
                if (act == 1) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 10'h2C7; end
                if (act == 2) pass_start = 1'b1;
                if (act == 3) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 10'h000; end
            end
            @(negedge clk);
            wr_en = 1'b0; pass_start = 1'b0;
            got[39-k] = ser_out;
            if (ser_strobe) strobes++;
            if (busy) busys++;
            if (act == 3 && k >= act_at && (ser_out || ser_strobe || busy)) quiet_bad++;
        end
        if (act == 3) begin
            chk(quiet_bad == 0, {"R10 abort quiet ", tag}, quiet_bad, 0);
            chk(busys == 1 + act_at, {"R10 busy until abort ", tag}, busys, 1 + act_at);
        end else begin
            chk(got == exp, {"R4 R5 R7 frame ", tag}, got, exp);
            chk(strobes == 40, {"R4 strobe count ", tag}, strobes, 40);
            chk(busys == 41, {"R6 busy length ", tag}, busys, 41);
        end
        @(negedge clk);
        chk(!busy && !ser_out && !ser_strobe, {"R6 R8 idle after ", tag},
            {busy, ser_out, ser_strobe}, 3'b000);
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !ser_out && !ser_strobe, "R1 reset outputs",
            {busy, ser_out, ser_strobe}, 3'b000);

        // R9: disabled, pass_start has no effect
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        chk(!busy && !ser_out && !ser_strobe, "R9 disabled start ignored",
            {busy, ser_out, ser_strobe}, 3'b000);

        // R1: reset probe values are zero
        wr_reg(3'd4, 10'h001);
        burst(40'h0, "R1 zero probes", 0, -1);

        // Vector table
        for (int v = 0; v < 5; v++) begin
            load(VEC[v]);
            burst(expect_frame(VEC[v]), $sformatf("vec%0d", v), 0, -1);
        end

        // R7: probe write during a burst, then visible next burst
        load(VEC[1]);
        burst(expect_frame(VEC[1]), "R7 write mid", 1, 5);
        burst(expect_frame({10'h2C7, VEC[1][29:0]}), "R7 next burst", 0, -1);

        // R8: restart pulse while busy
        burst(expect_frame({10'h2C7, VEC[1][29:0]}), "R8 restart", 2, 20);
        @(negedge clk);
        chk(!busy, "R8 no second frame", busy, 0);

        // R2: writes to unused addresses change nothing
        wr_reg(3'd5, 10'h3FF);
        wr_reg(3'd7, 10'h000);
        burst(expect_frame({10'h2C7, VEC[1][29:0]}), "R2 unused addr", 0, -1);

        // R10: abort mid-burst
        burst(40'h0, "R10", 3, 12);
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        chk(!busy && !ser_out, "R9 after abort disabled", {busy, ser_out}, 2'b00);

        // R5: upper bits on narrow probes dropped, probe 0 keeps all bits
        wr_reg(3'd4, 10'h001);
        load({10'h3C0, 10'h300, 10'h2FF, 10'h100});
        burst({10'h3C0, 10'h000, 10'h0FF, 10'h000}, "R5 narrow mask", 0, -1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule